// File: doc/BRIEF.md
# Bus-Master Disk DMA Register File

This block holds the software-visible control state of one bus-mastering disk DMA channel. Software reaches it over a small register bus with a 32-bit data path and per-byte write enables. Three registers are held: a command byte, a status byte and a 32-bit base pointer to the descriptor table in memory. The command byte drives the run and direction controls of a separate transfer engine. The engine reports back through three single-cycle pulses: done, error and interrupt.

The status byte holds three kinds of bit. The active bit is owned by hardware. The error and interrupt flags are sticky and are cleared by writing one to them. The two per-drive DMA-capable flags are plain storage for software. A completion summary output is high only when the finished-transfer pattern is present: interrupt set, error clear and engine idle. Software uses it to decide whether a transfer succeeded.

Register layout, as byte addresses on the bus: word 0 (address 0x0) carries the command byte in lane 0 (bits 7:0) and the status byte in lane 2 (bits 23:16). Word 1 (address 0x4) is the table pointer. Lanes 1 and 3 of word 0, and every other word, read as zero and ignore writes.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every register reads zero, and eng_start, eng_to_mem, tbl_base and irq_out are all low.
- R2: A write to word 0 with byte enable 0 set loads the whole command byte from wdata[7:0]. eng_start follows command bit 0. When byte enable 0 is clear, the command byte is unchanged.
- R3: eng_to_mem follows command bit 3. A 1 means data moves from the drive into memory, and a 0 means memory to drive.
- R4: Status bit 0 (read at bit 16) is the active bit, and software cannot write it. It goes to 1 when command bit 0 is written as 1. It goes to 0 when command bit 0 is written as 0, or when eng_done pulses while no such command write is in the same cycle.
- R5: Status bit 1 (the error flag, bit 17) and status bit 2 (the interrupt flag, bit 18) are set by the eng_err and eng_irq pulses. Writing 1 to a flag through lane 2 clears it. Writing 0 leaves it unchanged.
- R6: If a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Status bits 5 and 6 (read at bits 21 and 22) are read-write DMA-capable flags for drive 0 and drive 1. Status bits 3, 4 and 7 always read zero.
- R8: Word 1 holds the 32-bit descriptor table base. Each byte lane is written only when its byte enable is set. tbl_base shows the stored value.
- R9: irq_out equals the interrupt flag, so it stays high until software clears the flag.
- R10: xfer_good is high exactly when status bits 2:0 equal binary 100.
- R11: Read data is registered. The value for a read appears on reg_rdata in the cycle after reg_rd, and it reflects the state before any write in that same cycle. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (4) | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| eng_done | input | 1 | One-cycle pulse: engine finished the transfer |
| eng_err | input | 1 | One-cycle pulse: engine saw an error |
| eng_irq | input | 1 | One-cycle pulse: engine raises an interrupt |
| eng_start | output | 1 | Run control to the engine |
| eng_to_mem | output | 1 | Direction: 1 = drive to memory |
| tbl_base | output | 32 | Descriptor table base address |
| irq_out | output | 1 | Interrupt request (the sticky flag) |
| xfer_good | output | 1 | Completion summary: the transfer succeeded |

## Verification
The in-line assertions check the following on every cycle:
- a set pulse on a flag always wins over a clearing write;
- a write of one clears a flag when no pulse arrives in the same cycle;
- the interrupt flag never drops unless software clears it;
- the active bit rises only after a start write;
- a command write always loads the command byte;
- reads of unmapped words return zero.

Only the bench's scenarios show the rest:
- the full set of completion-status outcomes over all eight combinations of active, error and interrupt;
- every pattern of clear bits;
- the priority between a done pulse and a start write in the same cycle;
- per-lane pointer writes under all sixteen byte-enable masks;
- the absence of effect for writes with lane 0 disabled.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // Word indices on the register bus
  localparam int unsigned WORD_CTL = 0;
  localparam int unsigned WORD_PTR = 1;
  // Byte lanes inside the control word
  localparam int unsigned LANE_CMD  = 0;
  localparam int unsigned LANE_STAT = 2;
  // Command byte fields
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  // Status byte fields
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;
  localparam int unsigned ST_CAP0 = 5;

  typedef struct packed {
    logic act;
    logic err;
    logic irq;
  } stat_flags_t;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg #(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] cmd_q
);
  always_ff @(posedge clk) begin
    if (rst)         cmd_q <= '0;
    else if (wr_stb) cmd_q <= wdata;
  end

  // R2
  cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> cmd_q == $past(wdata));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_DRIVES = 2,
  parameter int unsigned BYTE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_wr,
  input  logic                  run_val,
  input  logic                  stat_wr,
  input  logic [BYTE_W-1:0]     stat_wdata,
  input  logic                  done_p,
  input  logic                  err_p,
  input  logic                  irq_p,
  output stat_flags_t           flags_q,
  output logic [NUM_DRIVES-1:0] cap_q
);
  logic clr_err, clr_irq;
  assign clr_err = stat_wr && stat_wdata[ST_ERR];
  assign clr_irq = stat_wr && stat_wdata[ST_IRQ];

  // Active bit: a command write takes priority over the done pulse
  always_ff @(posedge clk) begin
    if (rst)         flags_q.act <= 1'b0;
    else if (run_wr) flags_q.act <= run_val;
    else if (done_p) flags_q.act <= 1'b0;
  end

  // Sticky flags: a hardware set wins over a write-one clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.err <= 1'b0;
      flags_q.irq <= 1'b0;
    end else begin
      if (err_p)        flags_q.err <= 1'b1;
      else if (clr_err) flags_q.err <= 1'b0;
      if (irq_p)        flags_q.irq <= 1'b1;
      else if (clr_irq) flags_q.irq <= 1'b0;
    end
  end

  // Per-drive capability bits
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)          cap_q[d] <= 1'b0;
      else if (stat_wr) cap_q[d] <= stat_wdata[ST_CAP0 + d];
    end
  end

  // R6
  err_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    err_p |=> flags_q.err);
  // R5
  err_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_wdata[ST_ERR] && !err_p) |=> !flags_q.err);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q.irq && !(stat_wr && stat_wdata[ST_IRQ])) |=> flags_q.irq);
  // R4
  act_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q.act) |-> $past(run_wr && run_val));
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int unsigned PTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [PTR_W/8-1:0] be,
  input  logic [PTR_W-1:0]   wdata,
  output logic [PTR_W-1:0]   ptr_q
);
  localparam int unsigned LANES = PTR_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q[l*8 +: 8] <= '0;
      else if (wr_stb && be[l])
        ptr_q[l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_DRIVES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_irq,
  output logic              eng_start,
  output logic              eng_to_mem,
  output logic [31:0]       tbl_base,
  output logic              irq_out,
  output logic              xfer_good
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]     word;
  logic                  sel_ctl, sel_ptr;
  logic                  cmd_wr, stat_wr, ptr_wr;
  logic [BYTE_W-1:0]     cmd_q;
  stat_flags_t           flags;
  logic [NUM_DRIVES-1:0] cap;
  logic [BYTE_W-1:0]     stat_byte;
  logic [DATA_W-1:0]     ptr_q;
  logic [DATA_W-1:0]     rd_mux;

  assign word    = reg_addr[ADDR_W-1:2];
  assign sel_ctl = (word == WIDX_W'(WORD_CTL));
  assign sel_ptr = (word == WIDX_W'(WORD_PTR));
  assign cmd_wr  = reg_wr && sel_ctl && reg_be[LANE_CMD];
  assign stat_wr = reg_wr && sel_ctl && reg_be[LANE_STAT];
  assign ptr_wr  = reg_wr && sel_ptr;

  bmdma_cmd_reg #(.CMD_W(BYTE_W)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (cmd_wr),
    .wdata  (reg_wdata[LANE_CMD*BYTE_W +: BYTE_W]),
    .cmd_q  (cmd_q)
  );

  bmdma_stat_reg #(.NUM_DRIVES(NUM_DRIVES), .BYTE_W(BYTE_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .run_wr     (cmd_wr),
    .run_val    (reg_wdata[LANE_CMD*BYTE_W + CMD_RUN]),
    .stat_wr    (stat_wr),
    .stat_wdata (reg_wdata[LANE_STAT*BYTE_W +: BYTE_W]),
    .done_p     (eng_done),
    .err_p      (eng_err),
    .irq_p      (eng_irq),
    .flags_q    (flags),
    .cap_q      (cap)
  );

  bmdma_ptr_reg #(.PTR_W(DATA_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (ptr_wr),
    .be     (reg_be[LANES-1:0]),
    .wdata  (reg_wdata[DATA_W-1:0]),
    .ptr_q  (ptr_q)
  );

  // Assemble the status byte; unused positions read zero
  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_ACT] = flags.act;
    stat_byte[ST_ERR] = flags.err;
    stat_byte[ST_IRQ] = flags.irq;
    for (int d = 0; d < NUM_DRIVES; d++)
      stat_byte[ST_CAP0 + d] = cap[d];
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctl) begin
      rd_mux[LANE_CMD*BYTE_W  +: BYTE_W] = cmd_q;
      rd_mux[LANE_STAT*BYTE_W +: BYTE_W] = stat_byte;
    end else if (sel_ptr) begin
      rd_mux = ptr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign eng_start  = cmd_q[CMD_RUN];
  assign eng_to_mem = cmd_q[CMD_DIR];
  assign tbl_base   = ptr_q;
  assign irq_out    = flags.irq;
  assign xfer_good  = flags.irq && !flags.err && !flags.act;

  // R11
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !sel_ctl && !sel_ptr) |=> reg_rdata == '0);
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eng_done, eng_err, eng_irq;
  logic        eng_start, eng_to_mem, irq_out, xfer_good;
  logic [31:0] tbl_base;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of the register state
  logic [7:0]  m_cmd;
  logic        m_act, m_err, m_irq;
  logic [1:0]  m_cap;
  logic [31:0] m_ptr;

  always #10 clk = ~clk;

  bmdma_regs uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_irq(eng_irq), .eng_start(eng_start), .eng_to_mem(eng_to_mem),
    .tbl_base(tbl_base), .irq_out(irq_out), .xfer_good(xfer_good)
  );

  function automatic logic [31:0] ctl_word();
    return {8'h00, 1'b0, m_cap, 2'b00, m_irq, m_err, m_act, 8'h00, m_cmd};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle with optional write and engine pulses; model updated alongside
  task automatic step(input logic wr, input int w, input logic [31:0] d,
                      input logic [3:0] be, input logic dn, input logic er,
                      input logic ir);
    @(negedge clk);
    reg_wr = wr; reg_addr = 4'(w * 4); reg_wdata = d; reg_be = be;
    eng_done = dn; eng_err = er; eng_irq = ir;
    @(posedge clk);
    if (dn) m_act = 1'b0;
    if (wr && w == 0) begin
      if (be[0]) begin m_cmd = d[7:0]; m_act = d[0]; end
      if (be[2]) begin
        if (d[17]) m_err = 1'b0;
        if (d[18]) m_irq = 1'b0;
        m_cap = d[22:21];
      end
    end
    if (wr && w == 1)
      for (int l = 0; l < 4; l++) if (be[l]) m_ptr[l*8 +: 8] = d[l*8 +: 8];
    if (er) m_err = 1'b1;
    if (ir) m_irq = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_done = 1'b0; eng_err = 1'b0; eng_irq = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(w * 4);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " eng_start"}, {31'b0, eng_start}, {31'b0, m_cmd[0]});
    chk({tag, " eng_to_mem"}, {31'b0, eng_to_mem}, {31'b0, m_cmd[3]});
    chk({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, m_irq});
    chk({tag, " xfer_good"}, {31'b0, xfer_good},
        {31'b0, (m_irq && !m_err && !m_act)});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_be = '0;
    reg_wdata = '0; eng_done = 1'b0; eng_err = 1'b0; eng_irq = 1'b0;
    m_cmd = '0; m_act = 1'b0; m_err = 1'b0; m_irq = 1'b0; m_cap = '0; m_ptr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(0, v); chk("R1 ctl word", v, 32'h0);
    rd(1, v); chk("R1 ptr word", v, 32'h0);
    chk("R1 tbl_base", tbl_base, 32'h0);
    check_outputs("R1");

    // R2 R3 sweep every command byte; other lanes disabled
    for (int c = 0; c < 256; c++) begin
      step(1'b1, 0, {24'hFFFFFF, 8'(c)}, 4'b0001, 1'b0, 1'b0, 1'b0);
      check_outputs("R2 R3 cmd sweep");
      rd(0, v); chk("R2 cmd readback", v, ctl_word());
    end
    // R2 lane 0 disabled leaves command untouched
    step(1'b1, 0, 32'h0000_0000, 4'b1010, 1'b0, 1'b0, 1'b0);
    rd(0, v); chk("R2 lane0 off", v, ctl_word());

    // R10 R9 R4 all combinations of active, error, interrupt
    for (int p = 0; p < 8; p++) begin
      step(1'b1, 0, 32'h0006_0000, 4'b0101, 1'b0, 1'b0, 1'b0);
      if (p[0]) step(1'b1, 0, 32'h0000_0001, 4'b0001, 1'b0, 1'b0, 1'b0);
      step(1'b0, 0, 32'h0, 4'b0000, 1'b0, p[1], p[2]);
      chk("R10 good", {31'b0, xfer_good}, {31'b0, (p == 4)});
      chk("R9 irq_out", {31'b0, irq_out}, {31'b0, p[2]});
      rd(0, v); chk("R4 R5 status", v, ctl_word());
    end

    // R5 R4 clear patterns over status bits 2:0
    for (int w = 0; w < 8; w++) begin
      step(1'b1, 0, 32'h0000_0001, 4'b0001, 1'b0, 1'b1, 1'b1);
      step(1'b1, 0, {13'b0, 3'(w), 16'h0}, 4'b0100, 1'b0, 1'b0, 1'b0);
      rd(0, v);
      chk("R5 w1c err", {31'b0, v[17]}, {31'b0, !w[1]});
      chk("R5 w1c irq", {31'b0, v[18]}, {31'b0, !w[2]});
      chk("R4 act not writable", {31'b0, v[16]}, 32'h1);
    end

    // R6 set wins over clear in the same cycle
    step(1'b1, 0, 32'h0006_0000, 4'b0100, 1'b0, 1'b1, 1'b1);
    rd(0, v); chk("R6 set wins", {29'b0, v[18:16]}, 32'h7);

    // R4 done clears active; start write beats done
    step(1'b0, 0, 32'h0, 4'b0000, 1'b1, 1'b0, 1'b0);
    rd(0, v); chk("R4 done clears", {31'b0, v[16]}, 32'h0);
    step(1'b1, 0, 32'h0000_0001, 4'b0001, 1'b1, 1'b0, 1'b0);
    rd(0, v); chk("R4 start beats done", {31'b0, v[16]}, 32'h1);
    step(1'b1, 0, 32'h0000_0000, 4'b0001, 1'b0, 1'b0, 1'b0);
    rd(0, v); chk("R4 stop clears", {31'b0, v[16]}, 32'h0);

    // R7 capability bits with reserved positions written as ones
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 0, {8'h00, 1'b1, 2'(c), 5'b11000, 16'h0}, 4'b0100, 1'b0, 1'b0, 1'b0);
      rd(0, v);
      chk("R7 caps", {30'b0, v[22:21]}, 32'(c));
      chk("R7 reserved zero", {29'b0, v[23], v[20:19]}, 32'h0);
    end

    // R8 pointer under every byte-enable mask
    for (int b = 0; b < 16; b++) begin
      step(1'b1, 1, 32'h1111_1111 * (b + 1), 4'(b), 1'b0, 1'b0, 1'b0);
      chk("R8 tbl_base", tbl_base, m_ptr);
      rd(1, v); chk("R8 ptr readback", v, m_ptr);
    end

    // R11 unmapped words and read-before-write ordering
    rd(2, v); chk("R11 unmapped 2", v, 32'h0);
    rd(3, v); chk("R11 unmapped 3", v, 32'h0);
    v = m_ptr;
    @(negedge clk);
    reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 4'h4; reg_be = 4'hF; reg_wdata = ~v;
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0; m_ptr = ~v;
    chk("R11 read sees old value", reg_rdata, v);
    chk("R11 write landed", tbl_base, m_ptr);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule